// File: doc/BRIEF.md
# Multi-Cycle Extended Arithmetic Unit

This block is an arithmetic coprocessor that sits beside a single-issue core and handles the operations that are too slow or too wide for the main datapath. It supports unsigned 32x32 multiply, unsigned 32-bit divide, unsigned 64-by-32 divide, and logical 64-bit shifts left and right. Operands reach the unit through write commands. Results leave the unit through a read command. Each command arrives on one command port, at most one per cycle.

Each arithmetic class keeps the engine for a fixed and exactly counted number of cycles, tracked by a single down-counter. A command that needs the engine while the counter is non-zero raises a stall toward the issue stage. The issue stage must hold that command until the stall drops. Operand writes never need the engine, so they pass freely while a long divide runs. The divider is a restoring loop that produces one quotient bit per clock.

Top module: `ext_arith_unit`

## Requirements
- R1: A synchronous reset leaves busy and cmd_stall low, and reading any result register afterwards returns zero.
- R2: Operand writes never stall, even while busy. Opcode 1 loads the low operand, opcode 2 the high operand and opcode 3 the divisor/multiplier/shift register. A write during a running operation does not change that operation's result.
- R3: Opcode 4 shifts the 64-bit value {high,low} left and opcode 5 shifts it right (logical), by the low 6 bits of the divisor register. HI/LO receive the 64-bit result and REM is cleared. The engine is never held afterwards, so a read issued next is not stalled.
- R4: Opcode 6 writes the unsigned 64-bit product of low and divisor registers into HI/LO and clears REM. The engine is held 2 cycles after issue, so a following read stalls exactly 2 cycles.
- R5: Opcode 7 divides low by divisor, unsigned. The quotient goes to LO, HI is cleared and the remainder goes to REM. The engine is held 33 cycles after issue.
- R6: Opcode 8 divides the 64-bit {high,low} by the divisor. HI/LO receive the 64-bit quotient and REM the remainder. The engine is held 65 cycles after issue.
- R7: Dividing by zero gives an all-ones quotient (all quotient bits of the operation; HI cleared for opcode 7) and the low operand as remainder. It still takes the full hold time.
- R8: A command with opcode 4 to 9 that arrives while busy raises cmd_stall and is not accepted. It is accepted in the first cycle busy is low.
- R9: Opcode 9 reads one result register, chosen by cmd_data[1:0]: 0 = LO, 1 = HI, 2 = REM, 3 = constant zero. rd_valid pulses, with rd_data, in the cycle after acceptance.
- R10: The hold counter drops by exactly one per cycle while non-zero, so busy stays high for exactly the hold count after issue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command opcode (0 and 10-15 do nothing) |
| cmd_data | input | W | Operand data or read selector |
| cmd_stall | output | 1 | Command needs the engine and the engine is held |
| busy | output | 1 | Engine held by a running operation |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | W | Read result |

## Verification
The assertions assume the issue stage obeys the stall: a stalled command stays on the port until it is accepted, so no new engine operation starts while the counter is non-zero. They also assume that commands are not driven during reset. The bench driver holds every stalled command until the stall falls and starts driving only after reset is released. This keeps the stimulus inside those assumptions while still hitting every hold length, divide by zero, and operand writes made in the middle of a divide.

// File: rtl/xau_pkg.sv
package xau_pkg;
  parameter int XAU_W     = 32;
  parameter int MUL_EXTRA = 2;

  typedef enum logic [3:0] {
    XOP_NOP   = 4'd0,
    XOP_WLO   = 4'd1,
    XOP_WHI   = 4'd2,
    XOP_WDV   = 4'd3,
    XOP_SHL   = 4'd4,
    XOP_SHR   = 4'd5,
    XOP_MUL   = 4'd6,
    XOP_DIV   = 4'd7,
    XOP_DIVW  = 4'd8,
    XOP_READ  = 4'd9
  } xau_op_e;

  function automatic logic uses_engine(input logic [3:0] op);
    return (op >= 4'd4) && (op <= 4'd9);
  endfunction

  function automatic logic is_write(input logic [3:0] op);
    return (op >= 4'd1) && (op <= 4'd3);
  endfunction
endpackage

// File: rtl/xau_busy_ctr.sv
module xau_busy_ctr #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          busy
);
  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/xau_divider.sv
module xau_divider #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           wide,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  input  logic           step,
  output logic [2*W-1:0] quo,
  output logic [W-1:0]   rem
);
  logic [W:0]     part;
  logic [W-1:0]   dvs;
  logic [2*W-1:0] sh;
  logic [W:0]     trial;
  logic           take;

  // one restoring step: bring in the next dividend bit, subtract if it fits
  assign trial = {part[W-1:0], sh[2*W-1]};
  assign take  = (trial >= {1'b0, dvs});

  always_ff @(posedge clk) begin
    if (rst) begin
      part <= '0;
      dvs  <= '0;
      sh   <= '0;
    end else if (start) begin
      part <= '0;
      dvs  <= divisor;
      sh   <= wide ? dividend : {dividend[W-1:0], {W{1'b0}}};
    end else if (step) begin
      part <= take ? (trial - {1'b0, dvs}) : trial;
      sh   <= {sh[2*W-2:0], take};
    end
  end

  assign quo = sh;
  assign rem = part[W-1:0];
endmodule

// File: rtl/ext_arith_unit.sv
module ext_arith_unit
  import xau_pkg::*;
#(
  parameter int W = XAU_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_valid,
  input  logic [3:0]   cmd_op,
  input  logic [W-1:0] cmd_data,
  output logic         cmd_stall,
  output logic         busy,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  localparam int DIV_HOLD  = W + 1;
  localparam int DIVW_HOLD = 2 * W + 1;
  localparam int CW        = $clog2(DIVW_HOLD + 1);
  localparam int SHW       = $clog2(2 * W);

  logic [W-1:0]  op_lo, op_hi, op_dv;
  logic [W-1:0]  res_lo, res_hi, res_rem;
  logic [W-1:0]  lat_lo, lat_dv;
  xau_op_e       lat_op;
  xau_op_e       op;
  logic [CW-1:0] cnt;
  logic [CW-1:0] load_val;

  // named internal events
  logic needs_eng, eng_fire, wr_fire, rd_fire, shift_fire;
  logic mul_fire, div_fire, divw_fire, ctr_load, finish, div_step;

  logic [2*W-1:0] dq;
  logic [W-1:0]   dr;
  logic [2*W-1:0] shift_res;
  logic [SHW-1:0] amt;

  assign op         = xau_op_e'(cmd_op);
  assign needs_eng  = cmd_valid && uses_engine(cmd_op);
  assign cmd_stall  = needs_eng && busy;
  assign eng_fire   = needs_eng && !busy;
  assign wr_fire    = cmd_valid && is_write(cmd_op);
  assign rd_fire    = eng_fire && (op == XOP_READ);
  assign shift_fire = eng_fire && (op == XOP_SHL || op == XOP_SHR);
  assign mul_fire   = eng_fire && (op == XOP_MUL);
  assign div_fire   = eng_fire && (op == XOP_DIV);
  assign divw_fire  = eng_fire && (op == XOP_DIVW);
  assign ctr_load   = mul_fire || div_fire || divw_fire;
  assign finish     = (cnt == CW'(1));
  assign div_step   = (cnt > CW'(1)) && (lat_op == XOP_DIV || lat_op == XOP_DIVW);

  always_comb begin
    load_val = CW'(MUL_EXTRA);
    if (div_fire)  load_val = CW'(DIV_HOLD);
    if (divw_fire) load_val = CW'(DIVW_HOLD);
  end

  assign amt       = op_dv[SHW-1:0];
  assign shift_res = (op == XOP_SHL) ? ({op_hi, op_lo} << amt) : ({op_hi, op_lo} >> amt);

  xau_busy_ctr #(.CW(CW)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (ctr_load),
    .load_val (load_val),
    .cnt      (cnt),
    .busy     (busy)
  );

  xau_divider #(.W(W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (div_fire || divw_fire),
    .wide     (divw_fire),
    .dividend ({op_hi, op_lo}),
    .divisor  (op_dv),
    .step     (div_step),
    .quo      (dq),
    .rem      (dr)
  );

  // operand registers and operation latch
  always_ff @(posedge clk) begin
    if (rst) begin
      op_lo  <= '0;
      op_hi  <= '0;
      op_dv  <= '0;
      lat_lo <= '0;
      lat_dv <= '0;
      lat_op <= XOP_NOP;
    end else begin
      if (wr_fire) begin
        case (op)
          XOP_WLO: op_lo <= cmd_data;
          XOP_WHI: op_hi <= cmd_data;
          default: op_dv <= cmd_data;
        endcase
      end
      if (ctr_load) begin
        lat_lo <= op_lo;
        lat_dv <= op_dv;
        lat_op <= op;
      end
    end
  end

  // result registers and read port
  always_ff @(posedge clk) begin
    if (rst) begin
      res_lo   <= '0;
      res_hi   <= '0;
      res_rem  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) begin
        case (cmd_data[1:0])
          2'd0:    rd_data <= res_lo;
          2'd1:    rd_data <= res_hi;
          2'd2:    rd_data <= res_rem;
          default: rd_data <= '0;
        endcase
      end
      if (shift_fire) begin
        {res_hi, res_lo} <= shift_res;
        res_rem          <= '0;
      end
      if (finish) begin
        case (lat_op)
          XOP_MUL: begin
            {res_hi, res_lo} <= {{W{1'b0}}, lat_lo} * {{W{1'b0}}, lat_dv};
            res_rem          <= '0;
          end
          XOP_DIV: begin
            res_hi  <= '0;
            res_lo  <= (lat_dv == '0) ? '1 : dq[W-1:0];
            res_rem <= (lat_dv == '0) ? lat_lo : dr;
          end
          XOP_DIVW: begin
            {res_hi, res_lo} <= (lat_dv == '0) ? '1 : dq;
            res_rem          <= (lat_dv == '0) ? lat_lo : dr;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/xau_checker.sv
module xau_checker #(
  parameter int CW        = 7,
  parameter int DIV_HOLD  = 33,
  parameter int DIVW_HOLD = 65,
  parameter int MUL_HOLD  = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic [3:0]    cmd_op,
  input logic          cmd_stall,
  input logic          busy,
  input logic          rd_valid,
  input logic [CW-1:0] cnt,
  input logic          rd_fire,
  input logic          shift_fire,
  input logic          mul_fire,
  input logic          div_fire,
  input logic          divw_fire
);
  assert_hold_count_R10: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  assert_stall_when_busy_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_stall |-> busy);

  assert_write_no_stall_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op >= 4'd1 && cmd_op <= 4'd3) |-> !cmd_stall);

  assert_shift_free_R3: assert property (@(posedge clk) disable iff (rst)
    shift_fire |=> !busy);

  assert_mul_hold_R4: assert property (@(posedge clk) disable iff (rst)
    mul_fire |=> (cnt == CW'(MUL_HOLD)));

  assert_div_hold_R5: assert property (@(posedge clk) disable iff (rst)
    div_fire |=> (cnt == CW'(DIV_HOLD)));

  assert_divw_hold_R6: assert property (@(posedge clk) disable iff (rst)
    divw_fire |=> (cnt == CW'(DIVW_HOLD)));

  assert_read_timing_R9: assert property (@(posedge clk) disable iff (rst)
    rd_fire |=> rd_valid);

  assert_read_origin_R9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_fire));
endmodule

bind ext_arith_unit xau_checker #(
  .CW        (CW),
  .DIV_HOLD  (DIV_HOLD),
  .DIVW_HOLD (DIVW_HOLD),
  .MUL_HOLD  (xau_pkg::MUL_EXTRA)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_stall  (cmd_stall),
  .busy       (busy),
  .rd_valid   (rd_valid),
  .cnt        (cnt),
  .rd_fire    (rd_fire),
  .shift_fire (shift_fire),
  .mul_fire   (mul_fire),
  .div_fire   (div_fire),
  .divw_fire  (divw_fire)
);

// File: tb/test_ext_arith_unit.sv
module test_ext_arith_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [3:0]  cmd_op;
  logic [31:0] cmd_data;
  logic        cmd_stall, busy, rd_valid;
  logic [31:0] rd_data;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  ext_arith_unit i_ext_arith_unit (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_stall(cmd_stall), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected rd_valid", 64'd1, 64'd0);
      end else begin
        check(tag_q.pop_front(), {32'd0, rd_data}, {32'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic send(input logic [3:0] op, input logic [31:0] d, output int stalls);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    stalls = 0;
    #1;
    while (cmd_stall) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string tag, output int stalls);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    send(4'd9, {30'd0, sel}, stalls);
  endtask

  task automatic load(input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] dv);
    int s;
    send(4'd1, lo, s);
    send(4'd2, hi, s);
    send(4'd3, dv, s);
  endtask

  task automatic read_all(input logic [63:0] hilo, input logic [31:0] rem, input string tag);
    int s;
    rd(2'd0, hilo[31:0], {tag, " LO"}, s);
    rd(2'd1, hilo[63:32], {tag, " HI"}, s);
    rd(2'd2, rem, {tag, " REM"}, s);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int s, n;
    logic [63:0] v;
    cmd_valid = 1'b0; cmd_op = 4'd0; cmd_data = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    check("R1 busy after reset", {63'd0, busy}, 64'd0);
    check("R1 stall after reset", {63'd0, cmd_stall}, 64'd0);
    read_all(64'd0, 32'd0, "R1 reset");

    // R3 shifts
    v = 64'h12345678_9abcdef0;
    load(v[31:0], v[63:32], 32'd4);
    send(4'd4, 0, s);
    rd(2'd0, 32'(v << 4), "R3 shl LO", s);
    check("R3 shift no stall", s, 0);
    read_all(v << 4, 32'd0, "R3 shl");
    load(v[31:0], v[63:32], 32'd36);
    send(4'd5, 0, s);
    read_all(v >> 36, 32'd0, "R3 shr36");
    load(v[31:0], v[63:32], 32'd0);
    send(4'd4, 0, s);
    read_all(v, 32'd0, "R3 shift0");

    // R4 multiply
    load(32'hffffffff, 32'd0, 32'hffffffff);
    send(4'd6, 0, s);
    rd(2'd0, 32'h00000001, "R4 mul LO", s);
    check("R4 mul stall count", s, 2);
    read_all(64'hffffffff * 64'hffffffff, 32'd0, "R4 mul max");
    load(32'd12345, 32'd0, 32'd6789);
    send(4'd6, 0, s);
    read_all(64'd12345 * 64'd6789, 32'd0, "R4 mul small");

    // R5 divide and R2 writes during busy
    load(32'd100, 32'd0, 32'd7);
    send(4'd7, 0, s);
    send(4'd1, 32'd5, s);
    check("R2 write stall count", s, 0);
    send(4'd3, 32'd0, s);
    check("R2 write stall count dv", s, 0);
    rd(2'd0, 32'd14, "R5 div LO", s);
    check("R5 div stall count", s, 31);
    read_all({32'd0, 32'd14}, 32'd2, "R5 div");
    load(32'hffffffff, 32'hdeadbeef, 32'd1);
    send(4'd7, 0, s);
    rd(2'd2, 32'd0, "R5 div REM", s);
    check("R5 div full stall", s, 33);
    read_all({32'd0, 32'hffffffff}, 32'd0, "R5 div by1");

    // R6 wide divide, R10 busy length
    v = 64'h01234567_89abcdef;
    load(v[31:0], v[63:32], 32'h1234);
    send(4'd8, 0, s);
    n = 0;
    @(negedge clk);
    while (busy) begin n++; @(negedge clk); end
    check("R10 R6 busy cycles", n, 65);
    read_all(v / 64'h1234, 32'(v % 64'h1234), "R6 divw");
    v = 64'hffffffff_fffffffe;
    load(v[31:0], v[63:32], 32'd3);
    send(4'd8, 0, s);
    rd(2'd0, 32'(v / 64'd3), "R6 divw LO", s);
    check("R6 divw stall count", s, 65);
    read_all(v / 64'd3, 32'(v % 64'd3), "R6 divw big");

    // R7 divide by zero
    load(32'h0badf00d, 32'h77, 32'd0);
    send(4'd7, 0, s);
    rd(2'd2, 32'h0badf00d, "R7 div0 REM", s);
    check("R7 div0 stall count", s, 33);
    read_all({32'd0, 32'hffffffff}, 32'h0badf00d, "R7 div0");
    send(4'd8, 0, s);
    rd(2'd1, 32'hffffffff, "R7 divw0 HI", s);
    check("R7 divw0 stall count", s, 65);
    read_all(64'hffffffff_ffffffff, 32'h0badf00d, "R7 divw0");

    // R8 engine op while busy is held then runs
    load(32'd1000, 32'd0, 32'd10);
    send(4'd7, 0, s);
    send(4'd6, 0, s);
    check("R8 mul behind div stall", s, 33);
    rd(2'd0, 32'd10000, "R8 queued mul LO", s);
    check("R8 read behind mul stall", s, 2);

    // R9 selector 3 reads zero
    rd(2'd3, 32'd0, "R9 sel3 zero", s);

    repeat (4) @(negedge clk);
    check("R9 all reads returned", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule